// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks reservations for load-linked / store-conditional pairs. It keeps one reservation slot for each requester. A slot holds a valid bit and the line address that the requester's last load-linked reserved. Completed load-linked and store-conditional operations enter through a valid/ready request channel. For each accepted operation the block returns one response, which carries a success bit and the requester ID. The cache returns the success bit of a store-conditional to the core.

Two plain control inputs can break reservations without a handshake:
- an ordinary write completion, which carries a line-present flag;
- an external invalidate.

Both take effect in the same cycle they are asserted. They are applied before the request in that cycle. A bypass mode bit makes every response report success and leaves the slots untouched by requests.

Back-pressure rules:
- The request channel accepts an operation when `op_valid` and `op_ready` are both high at a clock edge.
- `op_ready` is high whenever the response register is empty or is being drained in that cycle (`res_ready` high).
- The response appears in the cycle after acceptance.
- The response stays stable while `res_valid` is high and `res_ready` is low.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no slot is valid, `res_valid` is 0 and `op_ready` is 1; a store-conditional issued right after reset fails.
- R2: A load-linked (`op_is_sc`=0) always returns `res_ok`=1 and reserves its line for its requester.
- R3: A store-conditional (`op_is_sc`=1) returns `res_ok`=1 only when its requester's slot holds its line, and returns 0 otherwise, including when another requester holds that line.
- R4: Every store-conditional outside bypass clears all reservations on its line, whether it succeeds or fails.
- R5: A new load-linked from a requester replaces that requester's earlier reservation.
- R6: A load-linked to a line reserved by another requester moves the reservation to the new requester.
- R7: A write with `wr_present`=1 clears every reservation on `wr_addr`; with `wr_present`=0 it has no effect.
- R8: A write and a request in the same cycle are ordered write first. A store-conditional to the written line then fails, while a load-linked to it keeps its new reservation.
- R9: An invalidate clears reservations on `inv_addr` only; other lines stay reserved.
- R10: With `bypass`=1 every response has `res_ok`=1, and requests neither set nor clear any slot.
- R11: A response appears one cycle after acceptance. It holds stable and `op_ready` stays 0 while `res_valid`=1 and `res_ready`=0.
- R12: `res_id` echoes the requester ID of the accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass | input | 1 | Mode bit: 1 = every request succeeds, slots untouched by requests |
| op_valid | input | 1 | Request valid |
| op_ready | output | 1 | Request ready |
| op_is_sc | input | 1 | 0 = load-linked, 1 = store-conditional |
| op_id | input | ID_W | Requester ID |
| op_addr | input | ADDR_W | Line address of the request |
| wr_valid | input | 1 | Ordinary write completion |
| wr_present | input | 1 | Written line is present in the cache |
| wr_addr | input | ADDR_W | Line address of the write |
| inv_valid | input | 1 | External invalidate |
| inv_addr | input | ADDR_W | Line address to invalidate |
| res_valid | output | 1 | Response valid |
| res_ready | input | 1 | Response ready |
| res_ok | output | 1 | Success bit |
| res_id | output | ID_W | Requester ID of the response |

## Verification
Some behaviours are checked by assertions on every cycle:
- the response is held under back-pressure;
- load-linked and bypass responses are always successes;
- a store-conditional without a matching reservation never succeeds;
- once a store-conditional or a present-line write completes, no slot still holds that line.

Other behaviours can only be shown by the bench's scenarios, because they depend on the history of events:
- which requester owns a line after competing load-linked operations;
- the write-before-request ordering within one cycle;
- that an invalidate leaves unrelated lines reserved;
- that bypass leaves existing reservations intact.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic {
    OP_LL = 1'b0,
    OP_SC = 1'b1
  } op_kind_e;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/llsc_slot.sv
module llsc_slot #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  input  logic              op_take,
  input  logic              op_set,
  input  logic [ADDR_W-1:0] op_addr,
  output logic              op_hit,
  output logic              held_valid,
  output logic [ADDR_W-1:0] held_addr
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;
  logic              survive;

  // writes and invalidates act before the request of the same cycle
  always_comb begin
    survive = vld_q
            && !(clr_wr && (addr_q == wr_addr))
            && !(inv_valid && (addr_q == inv_addr));
    op_hit  = survive && (addr_q == op_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (op_set) begin
      vld_q  <= 1'b1;
      addr_q <= op_addr;
    end else if (op_take && op_hit) begin
      vld_q  <= 1'b0;
    end else begin
      vld_q  <= survive;
    end
  end

  assign held_valid = vld_q;
  assign held_addr  = addr_q;
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            ok_in,
  input  logic [ID_W-1:0] id_in,
  input  logic            res_ready,
  output logic            can_load,
  output logic            res_valid,
  output logic            res_ok,
  output logic [ID_W-1:0] res_id
);
  assign can_load = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_id    <= '0;
    end else if (load) begin
      res_valid <= 1'b1;
      res_ok    <= ok_in;
      res_id    <= id_in;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 16,
  localparam int ID_W   = id_width(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_is_sc,
  input  logic [ID_W-1:0]   op_id,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              wr_valid,
  input  logic              wr_present,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_ok,
  output logic [ID_W-1:0]   res_id
);
  op_kind_e                  kind;
  logic                      fire;
  logic                      take;
  logic                      clr_wr;
  logic                      own_hit;
  logic                      ok_next;
  logic [NUM_REQ-1:0]        hit;
  logic [NUM_REQ-1:0]        slot_valid;
  logic [NUM_REQ*ADDR_W-1:0] slot_addr;

  assign kind   = op_kind_e'(op_is_sc);
  assign fire   = op_valid && op_ready;
  assign take   = fire && !bypass;
  assign clr_wr = wr_valid && wr_present;

  for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
    localparam logic [ID_W-1:0] SLOT_ID = ID_W'(g);
    llsc_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_wr     (clr_wr),
      .wr_addr    (wr_addr),
      .inv_valid  (inv_valid),
      .inv_addr   (inv_addr),
      .op_take    (take),
      .op_set     (take && (kind == OP_LL) && (op_id == SLOT_ID)),
      .op_addr    (op_addr),
      .op_hit     (hit[g]),
      .held_valid (slot_valid[g]),
      .held_addr  (slot_addr[g*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    own_hit = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (op_id == ID_W'(i)) own_hit = hit[i];
    end
    ok_next = bypass || (kind == OP_LL) || own_hit;
  end

  llsc_resp #(.ID_W(ID_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .ok_in     (ok_next),
    .id_in     (op_id),
    .res_ready (res_ready),
    .can_load  (op_ready),
    .res_valid (res_valid),
    .res_ok    (res_ok),
    .res_id    (res_id)
  );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bypass,
  input logic                      op_valid,
  input logic                      op_ready,
  input logic                      op_is_sc,
  input logic [ID_W-1:0]           op_id,
  input logic [ADDR_W-1:0]         op_addr,
  input logic                      wr_valid,
  input logic                      wr_present,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic                      res_ok,
  input logic [ID_W-1:0]           res_id,
  input logic [NUM_REQ-1:0]        slot_valid,
  input logic [NUM_REQ*ADDR_W-1:0] slot_addr
);
  logic              fire;
  logic [ADDR_W-1:0] op_addr_q;
  logic [ADDR_W-1:0] wr_addr_q;
  logic              op_line_held;
  logic              wr_line_held;
  logic              own_pre;

  assign fire = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_addr_q <= '0;
      wr_addr_q <= '0;
    end else begin
      op_addr_q <= op_addr;
      wr_addr_q <= wr_addr;
    end
  end

  always_comb begin
    op_line_held = 1'b0;
    wr_line_held = 1'b0;
    own_pre      = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (slot_valid[i] && slot_addr[i*ADDR_W +: ADDR_W] == op_addr_q) op_line_held = 1'b1;
      if (slot_valid[i] && slot_addr[i*ADDR_W +: ADDR_W] == wr_addr_q) wr_line_held = 1'b1;
      if (op_id == ID_W'(i) && slot_valid[i] && slot_addr[i*ADDR_W +: ADDR_W] == op_addr)
        own_pre = 1'b1;
    end
  end

  a_r11_hold_response: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_ok) && $stable(res_id));

  a_r11_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !op_ready);

  a_r2_ll_succeeds: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !op_is_sc |=> res_valid && res_ok);

  a_r10_bypass_ok: assert property (@(posedge clk) disable iff (!rst_n)
    fire && bypass |=> res_valid && res_ok);

  a_r3_no_false_success: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_is_sc && !bypass && !own_pre |=> !res_ok);

  a_r12_id_echo: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_id == $past(op_id));

  a_r4_sc_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_is_sc && !bypass |=> !op_line_held);

  a_r7_write_clears_line: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_present
    && !(fire && !op_is_sc && !bypass && op_addr == wr_addr) |=> !wr_line_held);
endmodule

bind llsc_monitor llsc_monitor_chk #(
  .NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .op_valid(op_valid),
  .op_ready(op_ready), .op_is_sc(op_is_sc), .op_id(op_id), .op_addr(op_addr),
  .wr_valid(wr_valid), .wr_present(wr_present), .wr_addr(wr_addr),
  .res_valid(res_valid), .res_ready(res_ready), .res_ok(res_ok), .res_id(res_id),
  .slot_valid(slot_valid), .slot_addr(slot_addr)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int NR = 4;
  localparam int AW = 16;
  localparam int IW = 2;
  localparam int VW = 56;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, op_valid = 1'b0, op_is_sc = 1'b0;
  logic [IW-1:0] op_id = '0;
  logic [AW-1:0] op_addr = '0, wr_addr = '0, inv_addr = '0;
  logic wr_valid = 1'b0, wr_present = 1'b0, inv_valid = 1'b0, res_ready = 1'b1;
  logic op_ready, res_valid, res_ok;
  logic [IW-1:0] res_id;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  llsc_monitor #(.NUM_REQ(NR), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .op_valid(op_valid),
    .op_ready(op_ready), .op_is_sc(op_is_sc), .op_id(op_id), .op_addr(op_addr),
    .wr_valid(wr_valid), .wr_present(wr_present), .wr_addr(wr_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .res_valid(res_valid),
    .res_ready(res_ready), .res_ok(res_ok), .res_id(res_id)
  );

  // {sc, id, addr, wr_en, wr_addr, wr_present, inv_en, inv_addr, bypass, expected ok}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b1,2'd0,16'h0010, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R1 SC after reset fails
    {1'b0,2'd0,16'h0010, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R2
    {1'b1,2'd0,16'h0010, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R3 success
    {1'b1,2'd0,16'h0010, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R4 cleared by success
    {1'b0,2'd1,16'h0020, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd2,16'h0020, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R3 wrong requester
    {1'b1,2'd1,16'h0020, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R4 cleared by failed SC
    {1'b0,2'd0,16'h0030, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b0,2'd0,16'h0040, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd0,16'h0030, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R5 old line dropped
    {1'b1,2'd0,16'h0040, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R5 new line held
    {1'b0,2'd1,16'h0050, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b0,2'd2,16'h0050, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd2,16'h0050, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R6 new owner
    {1'b1,2'd1,16'h0050, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R6 old owner lost
    {1'b0,2'd3,16'h0060, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd0,16'h0070, 1'b1,16'h0060,1'b0, 1'b0,16'h0, 1'b0, 1'b0},
    {1'b1,2'd3,16'h0060, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R7 absent write ignored
    {1'b0,2'd3,16'h0061, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd0,16'h0000, 1'b1,16'h0061,1'b1, 1'b0,16'h0, 1'b0, 1'b0},
    {1'b1,2'd3,16'h0061, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R7 present write clears
    {1'b0,2'd1,16'h0080, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd1,16'h0080, 1'b1,16'h0080,1'b1, 1'b0,16'h0, 1'b0, 1'b0}, // R8 write before SC
    {1'b0,2'd1,16'h0090, 1'b1,16'h0090,1'b1, 1'b0,16'h0, 1'b0, 1'b1}, // R8 write before LL
    {1'b1,2'd1,16'h0090, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R8 LL kept
    {1'b0,2'd2,16'h00A0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b0,2'd3,16'h00B0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd0,16'h0001, 1'b0,16'h0,1'b0, 1'b1,16'h00A0, 1'b0, 1'b0},
    {1'b1,2'd3,16'h00B0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R9 other line kept
    {1'b1,2'd2,16'h00A0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}, // R9 invalidated
    {1'b0,2'd0,16'h00C0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1},
    {1'b1,2'd1,16'h00D0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b1, 1'b1}, // R10 bypass ok
    {1'b1,2'd0,16'h00C0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b1, 1'b1}, // R10
    {1'b1,2'd0,16'h00C0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b1}, // R10 slot untouched
    {1'b0,2'd2,16'h00E0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b1, 1'b1}, // R10
    {1'b1,2'd2,16'h00E0, 1'b0,16'h0,1'b0, 1'b0,16'h0, 1'b0, 1'b0}  // R10 bypass LL no reserve
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 op_ready", 32'(op_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      @(negedge clk);
      op_valid   = 1'b1;
      op_is_sc   = v[55];
      op_id      = v[54:53];
      op_addr    = v[52:37];
      wr_valid   = v[36];
      wr_addr    = v[35:20];
      wr_present = v[19];
      inv_valid  = v[18];
      inv_addr   = v[17:2];
      bypass     = v[1];
      @(posedge clk);
      @(negedge clk);
      op_valid = 1'b0; wr_valid = 1'b0; inv_valid = 1'b0; bypass = 1'b0;
      check($sformatf("R11 vec%0d valid", i), 32'(res_valid), 32'd1);
      check($sformatf("R3 vec%0d ok", i), 32'(res_ok), 32'(v[0]));
      check($sformatf("R12 vec%0d id", i), 32'(res_id), 32'(v[54:53]));
    end

    // R11 back-pressure
    @(negedge clk);
    res_ready = 1'b0;
    op_valid = 1'b1; op_is_sc = 1'b0; op_id = 2'd1; op_addr = 16'h0100;
    @(posedge clk);
    @(negedge clk);
    check("R11 resp after accept", 32'(res_valid), 32'd1);
    check("R11 stalled ready", 32'(op_ready), 32'd0);
    op_is_sc = 1'b1; op_id = 2'd2;
    @(posedge clk);
    @(negedge clk);
    check("R11 held id", 32'(res_id), 32'd1);
    check("R11 held ok", 32'(res_ok), 32'd1);
    check("R11 still stalled", 32'(op_ready), 32'd0);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R12 next resp id", 32'(res_id), 32'd2);
    check("R3 other requester SC", 32'(res_ok), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R11 drained", 32'(res_valid), 32'd0);
    finish_up();
  end
endmodule